// File: doc/BRIEF.md
# Polarity-Selectable Single PWM Generator

This block generates one pulse-width-modulated output from the system clock. An up-counter starts at 0001h and advances once per clock while the block is enabled. When the count equals a programmed match value, the output switches from its idle level to its active level. When the count equals a programmed period (reload) value, the output goes back to idle, the count restarts at 0001h and a one-cycle interrupt pulse is raised. A polarity bit selects the idle level, and the active level is its inverse.

Software programs the block through a byte-wide write port. Each 16-bit value is split into bytes. One control byte holds the enable and polarity bits. The present count can be read at any time on a parallel output. Counter width, data width and address width are parameters. Elaboration checks keep these parameters consistent.

Top module: `pwm_single_gen`

## Requirements
- R1: After reset, count_o is 0001h, pwm_o is 0 and irq_o is 0.
- R2: While the enable bit is 0 (two cycles after it was cleared), count_o holds 0001h, pwm_o equals the polarity bit and irq_o stays 0.
- R3: While enabled, count_o rises by one per clock, except that in the cycle after count_o equals the reload value it reads 0001h.
- R4: irq_o is high for exactly the cycle that follows a cycle in which count_o equals the reload value while enabled, and is low otherwise.
- R5: In the cycle after count_o equals the match value (and differs from reload) while enabled, pwm_o is the inverse of the polarity bit.
- R6: In the cycle after count_o equals the reload value while enabled, pwm_o equals the polarity bit. A match value of 0, or a match value at or above reload, keeps pwm_o at the polarity level for the whole period.
- R7: For 1 <= match < reload, each period lasts reload cycles. pwm_o sits at the polarity level for match cycles and at the inverse level for reload-match cycles. Polarity 0 gives low-then-high and polarity 1 gives high-then-low.
- R8: Write addresses are as follows: 0 is the match low byte, 1 the match high byte, 2 the reload low byte and 3 the reload high byte. Address 4 is control, with bit 0 as enable and bit 1 as polarity. Writes to addresses 5 to 7 change nothing.
- R9: In the first cycle after enable is written to 1 from 0, count_o reads 0001h and pwm_o is at the polarity level. Counting proceeds from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register byte address |
| wr_data | input | 8 | Register write byte |
| count_o | output | 16 | Present counter value |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | One-cycle end-of-period pulse |

## Verification
Directed cases cover a normal duty cycle under both polarities, which shows whether the idle and active levels are placed correctly. They also cover match equal to reload, match above reload and match of zero, which show whether the reload event takes priority and whether the output wrongly goes active. Reload values of 1 and 2 test the restart path when it is taken on every cycle or on every other cycle. A match and reload that need their high bytes test the byte lanes. Writes to unused addresses followed by measured durations show that those addresses are ignored. Random match, reload and polarity triples are then compared cycle by cycle, and period by period, against bench functions.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_POL_BIT = 1;

   typedef struct packed {
      logic pol;
      logic en;
   } pwm_ctrl_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  match_o,
   output logic [CNT_W-1:0]  reload_o,
   output pwm_pkg::pwm_ctrl_t ctrl_o
);
   localparam int NUM_BYTES = CNT_W / DATA_W;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * NUM_BYTES);

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
      localparam logic [ADDR_W-1:0] M_ADDR = ADDR_W'(i);
      localparam logic [ADDR_W-1:0] R_ADDR = ADDR_W'(NUM_BYTES + i);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            match_o[i*DATA_W +: DATA_W]  <= '0;
            reload_o[i*DATA_W +: DATA_W] <= '0;
         end else if (wr_en) begin
            if (wr_addr == M_ADDR) match_o[i*DATA_W +: DATA_W] <= wr_data;
            if (wr_addr == R_ADDR) reload_o[i*DATA_W +: DATA_W] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= '0;
      end else if (wr_en && wr_addr == CTRL_ADDR) begin
         ctrl_o.en  <= wr_data[pwm_pkg::CTRL_EN_BIT];
         ctrl_o.pol <= wr_data[pwm_pkg::CTRL_POL_BIT];
      end
   end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int CNT_W = 16,
   parameter logic [CNT_W-1:0] START_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count_o,
   output logic             at_reload_o,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign at_reload_o = (count_o == reload);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_o <= START_VAL;
         irq_o   <= 1'b0;
      end else begin
         irq_o <= en && at_reload_o;
         if (!en || at_reload_o) count_o <= START_VAL;
         else                    count_o <= count_o + ONE;
      end
   end
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             pol,
   input  logic             at_reload,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] match,
   output logic             pwm_o
);
   logic active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                active_q <= 1'b0;
      else if (!en || at_reload) active_q <= 1'b0;
      else if (count == match)   active_q <= 1'b1;
   end

   assign pwm_o = pol ^ active_q;
endmodule

// File: rtl/pwm_single_gen.sv
module pwm_single_gen #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic              pwm_o,
   output logic              irq_o
);
   localparam int NUM_BYTES = CNT_W / DATA_W;

   if (CNT_W % DATA_W != 0) begin : g_chk_width
      $error("CNT_W must be a multiple of DATA_W");
   end
   if ((2 ** ADDR_W) <= 2 * NUM_BYTES) begin : g_chk_addr
      $error("ADDR_W too small for register map");
   end

   logic [CNT_W-1:0]   match_q;
   logic [CNT_W-1:0]   reload_q;
   pwm_pkg::pwm_ctrl_t ctrl_q;
   logic               at_reload;

   pwm_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .match_o(match_q), .reload_o(reload_q), .ctrl_o(ctrl_q)
   );

   pwm_counter #(.CNT_W(CNT_W), .START_VAL(CNT_W'(1))) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .reload(reload_q),
      .count_o(count_o), .at_reload_o(at_reload), .irq_o(irq_o)
   );

   pwm_outstage #(.CNT_W(CNT_W)) u_out (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .pol(ctrl_q.pol),
      .at_reload(at_reload), .count(count_o), .match(match_q), .pwm_o(pwm_o)
   );
endmodule

// File: rtl/pwm_single_gen_checker.sv
module pwm_single_gen_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             pol,
   input logic [CNT_W-1:0] match,
   input logic [CNT_W-1:0] reload,
   input logic [CNT_W-1:0] count_o,
   input logic             pwm_o,
   input logic             irq_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && count_o != reload) |=> (count_o == $past(count_o) + ONE));

   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && count_o == reload) |=> (count_o == ONE && irq_o));

   assert_irq_only_after_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && count_o == reload) |=> !irq_o);

   assert_active_after_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && count_o == match && count_o != reload) |=> (pwm_o != pol));

   assert_idle_after_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && count_o == reload) |=> (pwm_o == pol));

   assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en)) |-> (count_o == ONE && pwm_o == pol && !irq_o));
endmodule

bind pwm_single_gen pwm_single_gen_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .pol(ctrl_q.pol),
   .match(match_q), .reload(reload_q), .count_o(count_o),
   .pwm_o(pwm_o), .irq_o(irq_o)
);

// File: tb/pwm_single_gen_tb.sv
module pwm_single_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SEED = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] count_o;
   logic        pwm_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_single_gen u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .count_o(count_o), .pwm_o(pwm_o), .irq_o(irq_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // bench model: is the output active for a given count value
   function automatic bit exp_active(int cnt, int m, int r);
      return (m >= 1 && m < r && cnt > m);
   endfunction

   function automatic int exp_idle_len(int m, int r);
      return (m >= 1 && m < r) ? m : r;
   endfunction

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int m, input int r, input bit pol, input bit poke_unused);
      int prev;
      int idle_n;
      int act_n;
      int ncyc;
      wr(4, {30'd0, pol, 1'b0});          // R8: control, enable off
      wr(0, m & 8'hFF);
      wr(1, (m >> 8) & 8'hFF);
      wr(2, r & 8'hFF);
      wr(3, (r >> 8) & 8'hFF);
      if (poke_unused) begin
         wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);   // R8: unused addresses
      end
      check(count_o == 16'd1, "R2 count held", count_o, 1);
      check(pwm_o == pol, "R2 idle level", pwm_o, pol);
      check(irq_o == 1'b0, "R2 irq low", irq_o, 0);
      wr(4, {30'd0, pol, 1'b1});
      check(count_o == 16'd1, "R9 start count", count_o, 1);
      check(pwm_o == pol, "R9 start level", pwm_o, pol);
      prev = count_o; idle_n = 1; act_n = 0;
      ncyc = 3 * r + 4;
      for (int c = 1; c < ncyc; c++) begin
         int expc;
         @(negedge clk);
         expc = (prev == r) ? 1 : prev + 1;
         check(count_o == 16'(expc), "R3 count", count_o, expc);
         check(irq_o == (prev == r), "R4 irq", irq_o, int'(prev == r));
         check(pwm_o == (pol ^ exp_active(count_o, m, r)), "R5 R6 level",
               pwm_o, int'(pol ^ exp_active(count_o, m, r)));
         if (count_o == 16'd1) begin
            check(idle_n == exp_idle_len(m, r), "R7 idle length", idle_n, exp_idle_len(m, r));
            check(act_n == r - exp_idle_len(m, r), "R7 active length", act_n,
                  r - exp_idle_len(m, r));
            idle_n = 0; act_n = 0;
         end
         if (pwm_o == pol) idle_n++; else act_n++;
         prev = count_o;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(SEED);
      repeat (3) @(negedge clk);
      check(count_o == 16'd1, "R1 reset count", count_o, 1);
      check(pwm_o == 1'b0, "R1 reset pwm", pwm_o, 0);
      check(irq_o == 1'b0, "R1 reset irq", irq_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(count_o == 16'd1, "R1 after release", count_o, 1);

      run(3, 10, 1'b0, 1'b0);      // R7 polarity 0
      run(3, 10, 1'b1, 1'b1);      // R7 polarity 1, R8 unused addresses
      run(5, 5, 1'b0, 1'b0);       // R6 match equals reload
      run(20, 8, 1'b1, 1'b0);      // R6 match above reload
      run(0, 6, 1'b0, 1'b0);       // R6 match zero
      run(0, 1, 1'b1, 1'b0);       // R3 reload of one
      run(1, 2, 1'b0, 1'b0);       // R5 shortest active phase
      run(16'h0102, 16'h0180, 1'b1, 1'b0); // R8 high bytes
      for (int k = 0; k < 12; k++) begin
         int r;
         int m;
         r = 2 + int'($urandom % 200);
         m = int'($urandom % (r + 20));
         run(m, r, 1'($urandom % 2), 1'b0);
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule